// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits beside a peripheral's register bus and watches each access for misuse by software. It catches four kinds of misuse on the bus: reading a register that can only be written, writing a register that can only be read, writing a protected configuration register while protection is enabled, and writing a control register whose key byte is wrong. A fifth kind, a non-secure read of secure data, and two hardware fault events (sequencer fault and clock glitch) arrive as single-cycle input pulses.

Every detected event is folded into one 32-bit read-only status word at offset 0xE8. Four sticky flags in that word record that something happened. A type code, a warning/error class bit and the offset of the last protection violation record what happened. Reading the status word returns its current value in the same cycle and clears the four flags. The type, class and offset fields keep their values until a later event replaces them. The register offsets that belong to each category, the key value and the key field position are parameters.

Top module: `access_guard_monitor`

## Requirements
- R1: After reset, every bit of the status word is 0.
- R2: A read of a write-only offset sets the software-error flag (bit 3) and loads type 0 and class 0 (bit 31 = 0) into the type field (bits 27:24).
- R3: A write to a read-only offset, including the status word at 0xE8, sets bit 3 and loads type 1 with class 0.
- R4: A write to a protected offset while `prot_en` is 1 sets the protection flag (bit 0) and bit 3, loads type 2 with class 1, and stores the write's offset in bits 23:8. With `prot_en` at 0, the same write changes nothing.
- R5: A write to a key-checked offset whose data bits 31:24 differ from 0xA5 sets bit 3 and loads type 3 with class 1. A write with the correct key changes nothing.
- R6: A pulse on `sec_read_viol` sets bit 3 and loads type 4 with class 1. Types 2, 3 and 4 always carry class 1, and types 0 and 1 always carry class 0.
- R7: A pulse on `seq_err_evt` sets bit 2. A pulse on `clk_glitch_evt` sets bit 1.
- R8: A read at 0xE8 drives the status word onto `status_rdata` in the same cycle and clears bits 3:0 at the following edge. Type, class and offset are kept. A read at any other offset drives 0 on `status_rdata`.
- R9: If an event arrives in the same cycle as a status read, its flag stays set. The read returns the value the word had before the event.
- R10: When several software errors occur in one cycle, the lowest type number is recorded. The offset field changes only when a protection violation occurs.
- R11: Bits 30:28 and 7:4 of the status word always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset of the access |
| bus_wdata | input | 32 | Write data, checked for the key byte |
| prot_en | input | 1 | Enables protected-register violation detection |
| sec_read_viol | input | 1 | Pulse: a non-secure read hit secure data |
| seq_err_evt | input | 1 | Pulse: internal sequencer fault |
| clk_glitch_evt | input | 1 | Pulse: clock glitch detected |
| status_rdata | output | 32 | Status word during a status read, 0 otherwise |

## Verification
The bench targets three corner cases. An event that lands on the same cycle as a status read must survive; a design where the clear wins would lose that event without any trace. Offset 0x04 is both protected and key-checked, and a write there with a bad key while protection is on must report type 2; a design with the wrong priority would report 3. Accesses that cause no protection violation, such as a bad-key write, a correct-key write and a read, must leave the stored offset unchanged; a design that captures every address would overwrite it. The bench also checks that the type, class and offset fields survive the read that clears the flags, and that a write to the status word counts as a write to a read-only register.

// File: rtl/access_guard_monitor.sv
module access_guard_monitor #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 16'h00E8,
  parameter int NUM_WO = 2,
  parameter logic [NUM_WO*ADDR_W-1:0] WO_LIST = {16'h0014, 16'h0010},
  parameter int NUM_RO = 2,
  parameter logic [NUM_RO*ADDR_W-1:0] RO_LIST = {16'h0024, 16'h0020},
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {16'h0008, 16'h0004},
  parameter int NUM_KEY = 2,
  parameter logic [NUM_KEY*ADDR_W-1:0] KEY_LIST = {16'h0004, 16'h0000},
  parameter int KEY_W = 8,
  parameter int KEY_LSB = 24,
  parameter logic [KEY_W-1:0] KEY_VAL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              prot_en,
  input  logic              sec_read_viol,
  input  logic              seq_err_evt,
  input  logic              clk_glitch_evt,
  output logic [31:0]       status_rdata
);
  localparam logic [31:0] KEY_MASK = 32'(((64'd1 << KEY_W) - 64'd1) << KEY_LSB);
  localparam logic [31:0] KEY_PAT  = 32'(KEY_VAL) << KEY_LSB;

  logic [NUM_WO-1:0]   wo_hit;
  logic [NUM_RO-1:0]   ro_hit;
  logic [NUM_PROT-1:0] prot_hit;
  logic [NUM_KEY-1:0]  key_hit;

  for (genvar g = 0; g < NUM_WO; g++) begin : g_wo
    assign wo_hit[g] = bus_addr == WO_LIST[g*ADDR_W +: ADDR_W];
  end
  for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
    assign ro_hit[g] = bus_addr == RO_LIST[g*ADDR_W +: ADDR_W];
  end
  for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
    assign prot_hit[g] = bus_addr == PROT_LIST[g*ADDR_W +: ADDR_W];
  end
  for (genvar g = 0; g < NUM_KEY; g++) begin : g_key
    assign key_hit[g] = bus_addr == KEY_LIST[g*ADDR_W +: ADDR_W];
  end

  logic rd, wr, stat_hit, rd_stat, key_bad;
  assign rd       = bus_valid & ~bus_write;
  assign wr       = bus_valid & bus_write;
  assign stat_hit = bus_addr == STATUS_OFF;
  assign rd_stat  = rd & stat_hit;
  assign key_bad  = ((bus_wdata ^ KEY_PAT) & KEY_MASK) != 32'd0;

  logic [4:0] errs;
  assign errs[0] = rd & (|wo_hit);
  assign errs[1] = wr & ((|ro_hit) | stat_hit);
  assign errs[2] = wr & prot_en & (|prot_hit);
  assign errs[3] = wr & (|key_hit) & key_bad;
  assign errs[4] = sec_read_viol;

  logic [3:0] typ;
  always_comb begin
    typ = 4'd0;
    for (int i = 4; i >= 0; i--)
      if (errs[i]) typ = 4'(i);
  end

  logic [3:0]  flag_q;
  logic [3:0]  typ_q;
  logic        cls_q;
  logic [15:0] off_q;
  logic [3:0]  flag_set;
  assign flag_set = {|errs, seq_err_evt, clk_glitch_evt, errs[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      typ_q  <= '0;
      cls_q  <= 1'b0;
      off_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~{4{rd_stat}}) | flag_set;
      if (|errs) begin
        typ_q <= typ;
        cls_q <= typ >= 4'd2;
      end
      if (errs[2]) off_q <= 16'(bus_addr);
    end
  end

  logic [31:0] word;
  assign word = {cls_q, 3'b000, typ_q, off_q, 4'b0000, flag_q};
  assign status_rdata = rd_stat ? word : 32'd0;
endmodule

module access_guard_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stat,
  input logic       prot_en,
  input logic       seq_err_evt,
  input logic       clk_glitch_evt,
  input logic [3:0] flag_q,
  input logic [3:0] typ_q,
  input logic       cls_q
);
  assert_class_matches_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cls_q == (typ_q >= 4'd2));
  assert_type_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    typ_q <= 4'd4);
  assert_seq_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_evt |=> flag_q[2]);
  assert_glitch_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_glitch_evt |=> flag_q[1]);
  assert_read_clears_glitch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !clk_glitch_evt) |=> !flag_q[1]);
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && seq_err_evt) |=> flag_q[2]);
  assert_wpvs_needs_prot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(prot_en));
  assert_wpvs_with_swe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q[0] |-> flag_q[3]);
endmodule

bind access_guard_monitor access_guard_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .prot_en(prot_en),
  .seq_err_evt(seq_err_evt), .clk_glitch_evt(clk_glitch_evt),
  .flag_q(flag_q), .typ_q(typ_q), .cls_q(cls_q)
);

// File: tb/access_guard_monitor_test.sv
module access_guard_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        prot_en = 1'b0, sec_read_viol = 1'b0, seq_err_evt = 1'b0, clk_glitch_evt = 1'b0;
  logic [31:0] status_rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  access_guard_monitor uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .prot_en(prot_en),
    .sec_read_viol(sec_read_viol), .seq_err_evt(seq_err_evt),
    .clk_glitch_evt(clk_glitch_evt), .status_rdata(status_rdata)
  );

  typedef struct packed {
    logic        v, w;
    logic [15:0] a;
    logic [31:0] d;
    logic        pe, sec, seq, cg;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'h0010, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h00000008, 8'd2 },  // R2
    '{1'b1, 1'b1, 16'h0020, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h01000008, 8'd3 },  // R3
    '{1'b1, 1'b1, 16'h00E8, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h01000008, 8'd3 },  // R3 status is read-only
    '{1'b1, 1'b1, 16'h0008, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h82000809, 8'd4 },  // R4
    '{1'b1, 1'b1, 16'h0008, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h82000800, 8'd4 },  // R4 protection off
    '{1'b1, 1'b1, 16'h0000, 32'h12000000,  1'b0, 1'b0, 1'b0, 1'b0, 32'h83000808, 8'd5 },  // R5 bad key
    '{1'b1, 1'b1, 16'h0000, 32'hA5000000,  1'b0, 1'b0, 1'b0, 1'b0, 32'h83000800, 8'd5 },  // R5 good key
    '{1'b0, 1'b0, 16'h0000, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 32'h84000808, 8'd6 },  // R6
    '{1'b0, 1'b0, 16'h0000, 32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 32'h84000804, 8'd7 },  // R7 sequencer
    '{1'b0, 1'b0, 16'h0000, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h84000802, 8'd7 },  // R7 glitch
    '{1'b1, 1'b1, 16'h0004, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h82000409, 8'd10},  // R10 type 2 beats 3
    '{1'b1, 1'b0, 16'h0014, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 32'h00000408, 8'd10},  // R10 type 0 beats 4, offset kept
    '{1'b1, 1'b1, 16'h0004, 32'hA5000000,  1'b1, 1'b0, 1'b0, 1'b0, 32'h82000409, 8'd4 },  // R4
    '{1'b1, 1'b0, 16'h0030, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h82000400, 8'd8 }   // R8 plain read
  };

  task automatic drive(input logic v, w, input logic [15:0] a, input logic [31:0] d,
                       input logic pe, sec, seq, cg);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    prot_en = pe; sec_read_viol = sec; seq_err_evt = seq; clk_glitch_evt = cg;
  endtask

  task automatic check(input logic [31:0] act, exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic read_status(input logic [31:0] exp, input int req, input string what,
                             input logic cg = 1'b0);
    drive(1'b1, 1'b0, 16'h00E8, 32'h0, 1'b0, 1'b0, 1'b0, cg);
    #2;
    check(status_rdata, exp, req, what);
    check(status_rdata & 32'h700000F0, 32'h0, 11, "reserved bits");  // R11
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    read_status(32'h0, 1, "reset state");  // R1

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].v, VEC[i].w, VEC[i].a, VEC[i].d, VEC[i].pe, VEC[i].sec, VEC[i].seq, VEC[i].cg);
      read_status(VEC[i].exp, int'(VEC[i].req), $sformatf("vector %0d", i));
    end

    // R8: flags clear after a read, fields kept
    drive(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    read_status(32'h82000404, 8, "flag visible before clear");
    read_status(32'h82000400, 8, "flags cleared, fields kept");

    // R8: non-status read returns 0 on rdata
    drive(1'b1, 1'b0, 16'h0010, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    #2;
    check(status_rdata, 32'h0, 8, "other offset reads 0");
    read_status(32'h00000408, 2, "write-only read after other reads");

    // R9: event on the same cycle as a status read
    read_status(32'h00000400, 9, "read returns pre-event value", 1'b1);
    read_status(32'h00000402, 9, "event survived clear");
    read_status(32'h00000400, 9, "cleared on next read");

    // R1: reset mid-run clears fields
    drive(1'b1, 1'b1, 16'h0008, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; bus_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_status(32'h0, 1, "reset after activity");

    drive(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule